// File: doc/BRIEF.md
# Three-Operand NaN Result Selector

This combinational unit decides which NaN a single-precision fused multiply-add `(a*b)+c` returns once any operand is a NaN. It takes the three operands, a flag from the datapath saying the product was zero times infinity, a two-bit priority policy, a default-result mode and the NaN encoding convention. It returns a two-bit choice code, the final 32-bit result and an invalid-operation flag.

Each operand is first classified as quiet NaN, signaling NaN or not a NaN, under one of two conventions for the top fraction bit. The selected policy then picks an operand or the default NaN. The chosen value is quieted before it leaves the block. The default-result mode is applied only after the choice has been made, so an invalid flag raised by the policy is never lost. The multiply-add datapath and the detection of zero times infinity both live outside this block.

Top module: `fma_nan_pick`

## Requirements
- R1: With `snan_hi`=0 an operand is a quiet NaN when the exponent is all ones and fraction bit 22 is 1, and a signaling NaN when the exponent is all ones, bit 22 is 0 and the fraction is nonzero. With `snan_hi`=1 it is signaling when the exponent is all ones and bit 22 is 1, and quiet when the exponent is all ones, bit 22 is 0 and fraction bits 21:0 are nonzero. Infinities and finite values are not NaNs.
- R2: `choice` is encoded as 0 = operand a, 1 = operand b, 2 = operand c and 3 = default NaN.
- R3: Under policy 0, if `infzero` is set and c is a quiet NaN, `invalid` is 1 and `choice` is 3.
- R4: Otherwise, policy 0 takes the first match in this order: c signaling (2), a signaling (0), b signaling (1), c quiet (2), a quiet (0). If none matches it takes b (1).
- R5: Under policy 1, if `infzero` is set, `invalid` is 1 and `choice` is 2.
- R6: Otherwise, policy 1 chooses a (0) if a is any NaN, else c (2) if c is any NaN, else b (1).
- R7: Policy 2 and policy 3 both choose a (0) if a is a NaN, else b (1) if b is a NaN, else c (2). They never produce choice 3.
- R8: `invalid` is 1 whenever any operand is a signaling NaN. Apart from R3 and R5, it is 0 otherwise.
- R9: When `dflt_mode` is 1, `result` is the default NaN. `choice` and `invalid` are the same as they would be with `dflt_mode` at 0.
- R10: A chosen signaling operand is quieted. With `snan_hi`=0, fraction bit 22 is set and the other bits are kept. With `snan_hi`=1, the result is the default NaN. A chosen quiet operand or non-NaN operand passes through unchanged, and choice 3 gives the default NaN.
- R11: The default NaN is 0x7FC00000 when `snan_hi`=0 and 0x7FBFFFFF when `snan_hi`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand |
| op_c | input | 32 | Addend |
| infzero | input | 1 | Product was zero times infinity |
| policy | input | 2 | Priority policy select (0, 1, or 2/3 for fallback) |
| dflt_mode | input | 1 | Force the default NaN as the result |
| snan_hi | input | 1 | NaN convention: 1 means fraction bit 22 set marks a signaling NaN |
| choice | output | 2 | Selected source code |
| result | output | 32 | Final NaN result |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The hardest cases to reach are those where two rules compete within one policy. Examples are a signaling b against a quiet c under policy 0, or zero times infinity with a signaling a under policy 1. Random operands almost never form NaNs at all. The stimulus therefore draws every operand from a weighted mix of quiet NaNs, signaling NaNs, infinities, zeros and ordinary values, encoded for the current convention. It sweeps all four policies with `infzero` and `dflt_mode` set at random. Directed vectors pin each ordering step, and the convention-1 quieting path, one at a time.

// File: rtl/fnp_pkg.sv
package fnp_pkg;
  typedef enum logic [1:0] {
    PICK_A    = 2'd0,
    PICK_B    = 2'd1,
    PICK_C    = 2'd2,
    PICK_DFLT = 2'd3
  } pick_t;

  typedef enum logic [1:0] {
    POL_SIG_FIRST = 2'd0,
    POL_SRC_ORDER = 2'd1,
    POL_PLAIN     = 2'd2,
    POL_PLAIN_ALT = 2'd3
  } policy_t;

  typedef struct packed {
    logic is_nan;
    logic is_quiet;
    logic is_sig;
  } nan_class_t;
endpackage

// File: rtl/fnp_classify.sv
module fnp_classify
  import fnp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] value,
  input  logic                  snan_hi,
  output nan_class_t            cls
);
  localparam int QBIT = FRAC_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              low_nz;

  assign exp_f   = value[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f  = value[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign low_nz  = |frac_f[QBIT-1:0];

  always_comb begin
    if (snan_hi) begin
      cls.is_sig   = exp_max & frac_f[QBIT];
      cls.is_quiet = exp_max & ~frac_f[QBIT] & low_nz;
    end else begin
      cls.is_quiet = exp_max & frac_f[QBIT];
      cls.is_sig   = exp_max & ~frac_f[QBIT] & low_nz;
    end
    cls.is_nan = cls.is_sig | cls.is_quiet;
  end
endmodule

// File: rtl/fnp_priority.sv
module fnp_priority
  import fnp_pkg::*;
(
  input  nan_class_t cls_a,
  input  nan_class_t cls_b,
  input  nan_class_t cls_c,
  input  logic       infzero,
  input  logic [1:0] policy,
  output logic [1:0] choice,
  output logic       rule_invalid
);
  pick_t   pick;
  policy_t pol;

  assign pol = policy_t'(policy);

  always_comb begin
    pick         = PICK_B;
    rule_invalid = 1'b0;
    unique case (pol)
      POL_SIG_FIRST: begin
        if (infzero && cls_c.is_quiet) begin
          rule_invalid = 1'b1;
          pick         = PICK_DFLT;
        end else if (cls_c.is_sig)   pick = PICK_C;
        else if (cls_a.is_sig)       pick = PICK_A;
        else if (cls_b.is_sig)       pick = PICK_B;
        else if (cls_c.is_quiet)     pick = PICK_C;
        else if (cls_a.is_quiet)     pick = PICK_A;
        else                         pick = PICK_B;
      end
      POL_SRC_ORDER: begin
        if (infzero) begin
          rule_invalid = 1'b1;
          pick         = PICK_C;
        end else if (cls_a.is_nan)   pick = PICK_A;
        else if (cls_c.is_nan)       pick = PICK_C;
        else                         pick = PICK_B;
      end
      default: begin
        if (cls_a.is_nan)            pick = PICK_A;
        else if (cls_b.is_nan)       pick = PICK_B;
        else                         pick = PICK_C;
      end
    endcase
  end

  assign choice = pick;
endmodule

// File: rtl/fnp_output.sv
module fnp_output
  import fnp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [2:0][EXP_W+FRAC_W:0] ops,
  input  nan_class_t [2:0]           cls,
  input  logic [1:0]                 choice,
  input  logic                       snan_hi,
  input  logic                       dflt_mode,
  output logic [EXP_W+FRAC_W:0]      result
);
  localparam int W    = EXP_W + FRAC_W + 1;
  localparam int QBIT = FRAC_W - 1;

  logic [W-1:0] dflt_nan;
  logic [W-1:0] picked;
  logic [W-1:0] quiet_mask;
  logic         picked_sig;

  always_comb begin
    dflt_nan = '0;
    dflt_nan[W-2:FRAC_W] = '1;
    if (snan_hi) dflt_nan[QBIT-1:0] = '1;
    else         dflt_nan[QBIT]     = 1'b1;
  end

  always_comb begin
    quiet_mask       = '0;
    quiet_mask[QBIT] = 1'b1;
  end

  always_comb begin
    picked     = ops[0];
    picked_sig = 1'b0;
    case (pick_t'(choice))
      PICK_A: begin picked = ops[0]; picked_sig = cls[0].is_sig; end
      PICK_B: begin picked = ops[1]; picked_sig = cls[1].is_sig; end
      PICK_C: begin picked = ops[2]; picked_sig = cls[2].is_sig; end
      default: begin picked = dflt_nan; picked_sig = 1'b0; end
    endcase
  end

  always_comb begin
    if (dflt_mode || choice == PICK_DFLT) result = dflt_nan;
    else if (picked_sig)                  result = snan_hi ? dflt_nan : (picked | quiet_mask);
    else                                  result = picked;
  end
endmodule

// File: rtl/fma_nan_pick.sv
module fma_nan_pick
  import fnp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  logic [EXP_W+FRAC_W:0] op_c,
  input  logic                  infzero,
  input  logic [1:0]            policy,
  input  logic                  dflt_mode,
  input  logic                  snan_hi,
  output logic [1:0]            choice,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  invalid
);
  localparam int N_OPS = 3;

  logic [N_OPS-1:0][EXP_W+FRAC_W:0] ops;
  nan_class_t [N_OPS-1:0]           cls;
  logic [N_OPS-1:0]                 sig_vec;
  logic                             rule_invalid;

  assign ops[0] = op_a;
  assign ops[1] = op_b;
  assign ops[2] = op_c;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    fnp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
      .value   (ops[gi]),
      .snan_hi (snan_hi),
      .cls     (cls[gi])
    );
    assign sig_vec[gi] = cls[gi].is_sig;
  end

  fnp_priority i_prio (
    .cls_a        (cls[0]),
    .cls_b        (cls[1]),
    .cls_c        (cls[2]),
    .infzero      (infzero),
    .policy       (policy),
    .choice       (choice),
    .rule_invalid (rule_invalid)
  );

  fnp_output #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_out (
    .ops       (ops),
    .cls       (cls),
    .choice    (choice),
    .snan_hi   (snan_hi),
    .dflt_mode (dflt_mode),
    .result    (result)
  );

  assign invalid = (|sig_vec) | rule_invalid;
endmodule

// File: rtl/fma_nan_pick_chk.sv
module fma_nan_pick_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic [EXP_W+FRAC_W:0] op_c,
  input logic                  infzero,
  input logic [1:0]            policy,
  input logic                  dflt_mode,
  input logic                  snan_hi,
  input logic [1:0]            choice,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  invalid
);
  localparam int QBIT = FRAC_W - 1;

  function automatic logic sig_of(input logic [EXP_W+FRAC_W:0] v, input logic hi);
    logic em;
    em = &v[EXP_W+FRAC_W-1:FRAC_W];
    return hi ? (em & v[QBIT]) : (em & ~v[QBIT] & (|v[QBIT-1:0]));
  endfunction

  function automatic logic quiet_of(input logic [EXP_W+FRAC_W:0] v, input logic hi);
    logic em;
    em = &v[EXP_W+FRAC_W-1:FRAC_W];
    return hi ? (em & ~v[QBIT] & (|v[QBIT-1:0])) : (em & v[QBIT]);
  endfunction

  logic [EXP_W+FRAC_W:0] dflt_v;
  always_comb begin
    dflt_v = '0;
    dflt_v[EXP_W+FRAC_W-1:FRAC_W] = '1;
    if (snan_hi) dflt_v[QBIT-1:0] = '1;
    else         dflt_v[QBIT]     = 1'b1;
  end

  always_comb begin
    AST_SIG_RAISES: assert (!(sig_of(op_a, snan_hi) || sig_of(op_b, snan_hi) ||
                              sig_of(op_c, snan_hi)) || invalid); // R8
    AST_DFLT_FORCE: assert (!dflt_mode || result == dflt_v); // R9
    AST_P1_INFZERO: assert (!(policy == 2'd1 && infzero) || (choice == 2'd2 && invalid)); // R5
    AST_P0_INFZERO: assert (!(policy == 2'd0 && infzero && quiet_of(op_c, snan_hi)) ||
                            (choice == 2'd3 && invalid)); // R3
    AST_NO_SIG_OUT: assert (!sig_of(result, snan_hi)); // R10
    AST_PLAIN_NODF: assert (policy < 2'd2 || choice != 2'd3); // R7
  end
endmodule

bind fma_nan_pick fma_nan_pick_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_fma_nan_pick_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .op_c      (op_c),
  .infzero   (infzero),
  .policy    (policy),
  .dflt_mode (dflt_mode),
  .snan_hi   (snan_hi),
  .choice    (choice),
  .result    (result),
  .invalid   (invalid)
);

// File: tb/test_fma_nan_pick.sv
module test_fma_nan_pick;
  logic        clk;
  logic        rst_n;
  logic [31:0] op_a, op_b, op_c;
  logic        infzero, dflt_mode, snan_hi;
  logic [1:0]  policy;
  logic [1:0]  choice;
  logic [31:0] result;
  logic        invalid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  fma_nan_pick i_fma_nan_pick (
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .infzero(infzero),
    .policy(policy), .dflt_mode(dflt_mode), .snan_hi(snan_hi),
    .choice(choice), .result(result), .invalid(invalid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit m_sig(input logic [31:0] v, input bit hi);
    bit em = (v[30:23] == 8'hFF);
    if (hi) return em && v[22];
    return em && !v[22] && (v[21:0] != 0);
  endfunction

  function automatic bit m_q(input logic [31:0] v, input bit hi);
    bit em = (v[30:23] == 8'hFF);
    if (hi) return em && !v[22] && (v[21:0] != 0);
    return em && v[22];
  endfunction

  function automatic logic [31:0] m_dflt(input bit hi);
    return hi ? 32'h7FBF_FFFF : 32'h7FC0_0000;
  endfunction

  function automatic logic [34:0] model(input logic [31:0] a, b, c, input bit iz,
                                        input int pol, input bit dm, input bit hi);
    bit as = m_sig(a, hi), bs = m_sig(b, hi), cs = m_sig(c, hi);
    bit aq = m_q(a, hi),   bq = m_q(b, hi),   cq = m_q(c, hi);
    int ch;
    bit inv = as || bs || cs;
    logic [31:0] src, r;
    if (pol == 0) begin
      if (iz && cq) begin inv = 1; ch = 3; end
      else if (cs) ch = 2; else if (as) ch = 0; else if (bs) ch = 1;
      else if (cq) ch = 2; else if (aq) ch = 0; else ch = 1;
    end else if (pol == 1) begin
      if (iz) begin inv = 1; ch = 2; end
      else if (as || aq) ch = 0; else if (cs || cq) ch = 2; else ch = 1;
    end else begin
      if (as || aq) ch = 0; else if (bs || bq) ch = 1; else ch = 2;
    end
    src = (ch == 0) ? a : (ch == 1) ? b : c;
    if (dm || ch == 3) r = m_dflt(hi);
    else if (m_sig(src, hi)) r = hi ? m_dflt(hi) : (src | 32'h0040_0000);
    else r = src;
    return {ch[1:0], r, inv};
  endfunction

  task automatic apply_check(input logic [31:0] a, b, c, input bit iz, input int pol,
                             input bit dm, input bit hi, input string tag);
    logic [34:0] exp_v;
    @(posedge clk);
    #1;
    op_a = a; op_b = b; op_c = c; infzero = iz; policy = pol[1:0];
    dflt_mode = dm; snan_hi = hi;
    exp_v = model(a, b, c, iz, pol, dm, hi);
    @(negedge clk);
    n_checks++;
    if ({choice, result, invalid} !== exp_v) begin
      n_fail++;
      $display("FAIL %s: choice=%0d result=%h invalid=%b expected choice=%0d result=%h invalid=%b",
               tag, choice, result, invalid, exp_v[34:33], exp_v[32:1], exp_v[0]);
    end
  endtask

  function automatic logic [31:0] gen_op(input bit hi);
    int k = $urandom_range(0, 5);
    logic [31:0] v = $urandom;
    case (k)
      0: begin v[30:23] = 8'hFF; v[22] = !hi; if (v[21:0] == 0) v[0] = 1'b1; end
      1: begin v[30:23] = 8'hFF; v[22] = hi;  if (!hi && v[21:0] == 0) v[1] = 1'b1; end
      2: v[30:0] = 31'h7F80_0000;
      3: v[30:0] = 31'h0;
      default: if (v[30:23] == 8'hFF) v[30] = 1'b0;
    endcase
    return v;
  endfunction

  localparam logic [31:0] QA = 32'h7FC0_0001, SA = 32'h7F80_0005;
  localparam logic [31:0] QB = 32'hFFC0_0002, SB = 32'hFF80_0003;
  localparam logic [31:0] QC = 32'h7FC0_0003, SC = 32'h7F80_0007;
  localparam logic [31:0] ONE = 32'h3F80_0000;

  initial begin
    rst_n = 1'b0;
    op_a = '0; op_b = '0; op_c = '0; infzero = 0; policy = 0; dflt_mode = 0; snan_hi = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R2: idle inputs, policy 0 falls through to b
    apply_check(0, 0, 0, 0, 0, 0, 0, "R2 idle");
    apply_check(SA, SB, SC, 0, 0, 0, 0, "R4 c signaling first");
    apply_check(SA, SB, ONE, 0, 0, 0, 0, "R4 a signaling");
    apply_check(QA, SB, QC, 0, 0, 0, 0, "R4 b signaling over c quiet");
    apply_check(QA, QB, QC, 0, 0, 0, 0, "R4 c quiet");
    apply_check(QA, QB, ONE, 0, 0, 0, 0, "R4 a quiet no invalid");
    apply_check(ONE, ONE, QC, 1, 0, 0, 0, "R3 infzero quiet c");
    apply_check(SA, ONE, QC, 1, 1, 0, 0, "R5 infzero policy 1");
    apply_check(ONE, SB, QC, 0, 1, 0, 0, "R6 c before b");
    apply_check(QA, QB, SC, 0, 1, 0, 0, "R6 a first");
    apply_check(ONE, QB, SC, 0, 2, 0, 0, "R7 plain b");
    apply_check(ONE, ONE, QC, 1, 3, 0, 0, "R7 alt code c");
    apply_check(SA, ONE, ONE, 0, 0, 1, 0, "R9 default mode keeps invalid");
    apply_check(ONE, ONE, QC, 1, 1, 1, 0, "R9 default mode policy 1");
    apply_check(SA, ONE, ONE, 0, 2, 0, 0, "R10 quiet by bit 22");
    apply_check(32'h7FC0_0001, ONE, ONE, 0, 0, 0, 1, "R10 convention 1 signaling");
    apply_check(32'h7F80_0001, ONE, ONE, 0, 2, 0, 1, "R1 convention 1 quiet passes");
    apply_check(32'h7F80_0000, QB, ONE, 0, 2, 0, 0, "R1 infinity is not NaN");
    apply_check(ONE, ONE, 32'h7FC0_0000, 1, 0, 1, 1, "R11 convention 1 default");
    for (int i = 0; i < 3000; i++) begin
      bit hi = $urandom_range(0, 1);
      int pol = $urandom_range(0, 3);
      apply_check(gen_op(hi), gen_op(hi), gen_op(hi), $urandom_range(0, 1), pol,
                  ($urandom_range(0, 3) == 0), hi,
                  (pol == 0) ? "R4 mix" : (pol == 1) ? "R6 mix" : "R7 mix");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule